// File: doc/BRIEF.md
# Row-Parity Self-Check Monitor for a Field-Symbol Pattern Generator

This block runs alongside a pattern generator whose state is six 3-bit field symbols. That generator's feedback polynomial has a root at x = 1, so the XOR sum of all six symbols never changes from one step to the next. Viewed bit by bit, the state falls into three rows. Row j gathers bit j of every symbol, and the parity of each row holds steady for the whole sequence. A seed with all rows even gives a linear distance-2 code. A seed with an odd row gives a nonlinear code that still has distance 2. In both cases the row parities are constant.

The monitor takes the generator state on every cycle. When the seed-load strobe is high, it stores the row parities of the state presented with the strobe as its reference. From the following cycle on, it compares the live row parities against that reference. Any single flipped state bit changes exactly one row parity. That raises a sticky error flag and marks the affected row in a sticky per-row vector. The monitor never duplicates the generator. Its cost is one XOR tree per row, a 3-bit reference and a small amount of control.

Top module: `rowpar_monitor`

## Requirements
- R1: After reset, errFlag is 0 and rowMismatch is 3'b000.
- R2: Symbol s occupies stateIn bits [3s+2:3s]. Row j is the XOR of bit j of all six symbols, so state bit b belongs to row b mod 3, and rowMismatch bit j reports row j.
- R3: When seedLoad is high at a clock edge, the row parities of stateIn at that edge become the reference, and errFlag and rowMismatch read 0 after that edge.
- R4: No comparison is made before the first seed load after reset. Arbitrary states then leave errFlag at 0.
- R5: Checking starts on the cycle after a load. If a state presented with seedLoad low differs from the reference in row j, errFlag is 1 and rowMismatch[j] is 1 after that same clock edge.
- R6: A fault-free run from a seed whose row parities are all even never sets errFlag.
- R7: A fault-free run from a seed with at least one odd row parity never sets errFlag.
- R8: errFlag and the set bits of rowMismatch stay set after the state returns to the reference parity, until reset or the next seed load.
- R9: Mismatches in different rows, at the same time or in different cycles, accumulate in rowMismatch.
- R10: A seed load while checking is active re-bases the reference. The state presented with the load is never itself flagged, whatever its parity.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| seedLoad | input | 1 | High in the cycle the generator takes its seed |
| stateIn | input | 18 | Current generator state, six 3-bit symbols |
| errFlag | output | 1 | Sticky corruption flag |
| rowMismatch | output | 3 | Sticky per-row parity mismatch vector |

## Verification
A wrong reference register or a broken row fold appears at the ports in one of two ways. A clean run raises a false errFlag, or an injected flip is missed or reported in the wrong rowMismatch bit. Both show up at the clock edge right after the state is presented. A wrong armed bit shows up as a flag before any seed load, or as a missed flip on the first cycle after a load. A wrong clear or sticky path shows up when the flag drops while the state returns to the correct parity, or stays set across a load.

// File: rtl/rowpar_pkg.sv
package rowpar_pkg;
  typedef struct packed {
    logic capture;
    logic clear;
    logic check;
  } ctlStrobes_t;
endpackage

// File: rtl/rowpar_fold.sv
module rowpar_fold #(
  parameter int SYM_W   = 3,
  parameter int NUM_SYM = 6,
  localparam int STATE_W = SYM_W * NUM_SYM
) (
  input  logic [STATE_W-1:0] stateIn,
  output logic [SYM_W-1:0]   rowPar
);
  // row j folds bit j of every symbol
  for (genvar j = 0; j < SYM_W; j++) begin : g_row
    logic [NUM_SYM-1:0] rowBits;
    for (genvar s = 0; s < NUM_SYM; s++) begin : g_sym
      assign rowBits[s] = stateIn[s*SYM_W + j];
    end
    assign rowPar[j] = ^rowBits;
  end
endmodule

// File: rtl/rowpar_ctrl.sv
module rowpar_ctrl
  import rowpar_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        seedLoad,
  output ctlStrobes_t strb
);
  logic armedQ;

  always_ff @(posedge clk) begin
    if (!rstN) armedQ <= 1'b0;
    else if (seedLoad) armedQ <= 1'b1;
  end

  always_comb begin
    strb.capture = seedLoad;
    strb.clear   = seedLoad;
    strb.check   = armedQ && !seedLoad;
  end

  AST_NO_CHECK_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !armedQ |-> !strb.check); // R4
  AST_ARMED_AFTER_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    seedLoad |=> armedQ); // R5
endmodule

// File: rtl/rowpar_dp.sv
module rowpar_dp
  import rowpar_pkg::*;
#(
  parameter int SYM_W = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobes_t      strb,
  input  logic [SYM_W-1:0] livePar,
  output logic             errFlag,
  output logic [SYM_W-1:0] rowMismatch
);
  logic [SYM_W-1:0] refQ;
  logic [SYM_W-1:0] diff;
  logic             errQ;
  logic [SYM_W-1:0] vecQ;

  assign diff = strb.check ? (livePar ^ refQ) : '0;

  always_ff @(posedge clk) begin
    if (!rstN) refQ <= '0;
    else if (strb.capture) refQ <= livePar;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      errQ <= 1'b0;
      vecQ <= '0;
    end else begin
      errQ <= errQ | (|diff);
      vecQ <= vecQ | diff;
    end
  end

  assign errFlag     = errQ;
  assign rowMismatch = vecQ;

  AST_LOAD_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!errFlag && rowMismatch == '0)); // R3
  AST_DETECT_NEXT: assert property (@(posedge clk) disable iff (!rstN)
    (strb.check && livePar != refQ) |=> errFlag); // R5
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (errFlag && !strb.clear) |=> errFlag); // R8
  AST_VEC_ACCUM: assert property (@(posedge clk) disable iff (!rstN)
    !strb.clear |=> ((rowMismatch & $past(rowMismatch)) == $past(rowMismatch))); // R9
endmodule

// File: rtl/rowpar_monitor.sv
module rowpar_monitor
  import rowpar_pkg::*;
#(
  parameter int SYM_W   = 3,
  parameter int NUM_SYM = 6,
  localparam int STATE_W = SYM_W * NUM_SYM
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               seedLoad,
  input  logic [STATE_W-1:0] stateIn,
  output logic               errFlag,
  output logic [SYM_W-1:0]   rowMismatch
);
  ctlStrobes_t      strb;
  logic [SYM_W-1:0] livePar;

  rowpar_fold #(.SYM_W(SYM_W), .NUM_SYM(NUM_SYM)) fold_i (
    .stateIn(stateIn), .rowPar(livePar));

  rowpar_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .seedLoad(seedLoad), .strb(strb));

  rowpar_dp #(.SYM_W(SYM_W)) dp_i (
    .clk(clk), .rstN(rstN), .strb(strb), .livePar(livePar),
    .errFlag(errFlag), .rowMismatch(rowMismatch));

  AST_RESET_QUIET: assert property (@(posedge clk)
    !rstN |=> (!errFlag && rowMismatch == '0)); // R1
endmodule

// File: tb/rowpar_monitor_tb.sv
module rowpar_monitor_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        seedLoad = 1'b0;
  logic [17:0] stateIn = '0;
  logic        errFlag;
  logic [2:0]  rowMismatch;
  int nChk = 0;
  int nBad = 0;
  logic [17:0] cur;

  always #4 clk = ~clk;

  rowpar_monitor dut_i (.clk(clk), .rstN(rstN), .seedLoad(seedLoad),
    .stateIn(stateIn), .errFlag(errFlag), .rowMismatch(rowMismatch));

  function automatic logic [2:0] gfMul(input logic [2:0] a, input logic [2:0] b);
    logic [2:0] r = '0;
    logic [2:0] x = a;
    for (int i = 0; i < 3; i++) begin
      if (b[i]) r = r ^ x;
      x = x[2] ? ({x[1:0], 1'b0} ^ 3'b101) : {x[1:0], 1'b0};
    end
    return r;
  endfunction

  // feedback coefficients of a polynomial with a root at x = 1
  function automatic logic [17:0] nextState(input logic [17:0] s);
    logic [2:0] phi [6] = '{3'd2, 3'd2, 3'd6, 3'd0, 3'd4, 3'd3};
    logic [2:0] fb = s[17:15];
    logic [17:0] n;
    n[2:0] = gfMul(phi[0], fb);
    for (int i = 1; i < 6; i++) n[i*3 +: 3] = s[(i-1)*3 +: 3] ^ gfMul(phi[i], fb);
    return n;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    nChk++;
    if (!ok) begin
      nBad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [17:0] st, input logic ld);
    @(negedge clk);
    stateIn = st;
    seedLoad = ld;
  endtask

  task automatic loadSeed(input logic [17:0] seed);
    step(seed, 1'b1);
    cur = nextState(seed);
  endtask

  task automatic runGood(input int n);
    for (int i = 0; i < n; i++) begin
      step(cur, 1'b0);
      cur = nextState(cur);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk(errFlag == 0 && rowMismatch == 0, "R1 reset", {errFlag, rowMismatch}, 0);
    rstN = 1'b1;
    for (int i = 0; i < 20; i++) step(18'h1 << i % 18, 1'b0);
    step(18'h0, 1'b0);
    chk(errFlag == 0, "R4 no check before load", errFlag, 0);
  endtask

  task automatic t_clean(input logic [17:0] seed, input string tag);
    loadSeed(seed);
    runGood(2000);
    step(cur, 1'b0);
    chk(errFlag == 0 && rowMismatch == 0, tag, {errFlag, rowMismatch}, 0);
  endtask

  task automatic t_flip(input int b, input int pre);
    loadSeed(18'o440000);
    runGood(pre);
    step(cur ^ (18'h1 << b), 1'b0);
    chk(errFlag == 0, "R5 quiet before flip", errFlag, 0);
    cur = nextState(cur);
    step(cur, 1'b0);
    chk(errFlag == 1, "R5 flip flagged next edge", errFlag, 1);
    chk(rowMismatch == 3'(1 << (b % 3)), "R2 row of flipped bit", rowMismatch, 1 << (b % 3));
    cur = nextState(cur);
    runGood(3);
    step(cur, 1'b0);
    chk(errFlag == 1 && rowMismatch == 3'(1 << (b % 3)), "R8 sticky",
        {errFlag, rowMismatch}, {1'b1, 3'(1 << (b % 3))});
  endtask

  task automatic t_multi();
    loadSeed(18'o123456);
    runGood(4);
    step(cur ^ 18'h011, 1'b0);
    cur = nextState(cur);
    step(cur, 1'b0);
    chk(rowMismatch == 3'b011, "R9 two rows at once", rowMismatch, 3'b011);
    cur = nextState(cur);
    step(cur ^ 18'h004, 1'b0);
    cur = nextState(cur);
    step(cur, 1'b0);
    chk(rowMismatch == 3'b111 && errFlag, "R9 accumulate later row", rowMismatch, 3'b111);
  endtask

  task automatic t_reload();
    // flag is set from t_multi; reload with odd-parity seed
    step(18'o000001, 1'b1);
    step(18'o000002, 1'b1);
    cur = nextState(18'o000002);
    step(cur, 1'b0);
    chk(errFlag == 0 && rowMismatch == 0, "R3 load clears", {errFlag, rowMismatch}, 0);
    cur = nextState(cur);
    runGood(50);
    step(cur, 1'b0);
    chk(errFlag == 0, "R10 re-based reference", errFlag, 0);
  endtask

  initial begin
    t_reset();
    t_clean(18'o440000, "R6 even seed clean run");
    t_clean(18'o000007, "R7 odd seed clean run");
    t_clean(18'o765432, "R7 mixed seed clean run");
    for (int b = 0; b < 18; b++) t_flip(b, (b == 0) ? 0 : 5 + b);
    t_multi();
    t_reload();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nChk++;
    nBad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  end
endmodule